// File: doc/BRIEF.md
# Floating-Point Truncate to Integral with Signed 64-bit Clamp

This unit takes one IEEE-754 operand, either single or double precision, and returns an integral value in the same format by discarding any fractional magnitude (rounding toward zero). The integral value must also fit the signed 64-bit integer range. NaN and infinity inputs, and any truncated value outside that range, are replaced by -2^63 encoded in the operand's format, and an Invalid flag is raised. An Inexact flag reports that the returned value differs numerically from the operand.

The result is a 128-bit register value. Only its lowest element (32 or 64 bits, by format) carries the rounded value. The bits above the element are taken from the previous destination contents when merge mode is on, and are cleared when it is off. An illegal format code produces a one-cycle undefined-operation pulse and leaves the result and flags untouched. The unit has one register stage: a request accepted on one clock edge is visible on the outputs after that edge.

Top module: `fp_trunc_i64`

## Requirements
- R1: A finite in-range operand with a fractional part returns the integral value nearest zero, for both signs (single 1.5 gives 1.0 as 0x3F800000; double -1.5 gives -1.0 as 0xBFF0000000000000).
- R2: A zero operand returns a zero with the operand's sign bit and raises neither flag.
- R3: Inexact (out_inexact) is 1 exactly when the returned value differs numerically from the operand. This includes magnitudes below 1.0 and subnormals, which return a zero of the operand's sign.
- R4: An operand whose unbiased exponent is at or above the fraction width (23 single, 52 double) is returned unchanged with no flags, provided it is in range.
- R5: NaN (quiet or signalling) and infinity of either sign return -2^63 (single 0xDF000000, double 0xC3E0000000000000) with out_invalid=1 and out_inexact=0.
- R6: A truncated value of +2^63 or more, or below -2^63, returns the same -2^63 encoding with out_invalid=1 and out_inexact=0. A value of exactly -2^63 is valid and raises no flag.
- R7: in_fmt=00 selects single precision: the operand is in_operand[31:0], bits [63:32] are ignored, and the result is in out_result[31:0]. in_fmt=01 selects double precision with the operand and result in bits [63:0].
- R8: The result bits above the element come from in_dest_prev when in_merge=1, and are zero when in_merge=0.
- R9: in_fmt=10 or 11 with in_valid=1 sets out_undef=1 for one cycle with out_valid=0. out_result, out_inexact and out_invalid keep their previous values.
- R10: out_valid is 1 in the cycle after a legal request, and 0 otherwise. Reset clears out_valid, out_undef, out_result and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_fmt | input | 2 | Format: 00 single, 01 double, 1x illegal |
| in_merge | input | 1 | 1: keep upper destination bits; 0: clear them |
| in_operand | input | 64 | Operand bits (single uses [31:0]) |
| in_dest_prev | input | 128 | Previous destination contents |
| out_valid | output | 1 | Result and flags updated this cycle |
| out_result | output | 128 | Destination value |
| out_inexact | output | 1 | Inexact flag of the last legal request |
| out_invalid | output | 1 | Invalid flag of the last legal request |
| out_undef | output | 1 | Illegal format seen on the last request |

## Verification
The assertions assume that in_fmt, in_merge, in_operand and in_dest_prev are stable and meaningful whenever in_valid is 1, and that they may hold anything when it is 0. The bench drives every input at the falling edge and holds the inputs for the whole cycle. It idles the bus between the illegal-format request and the next legal one, so the held-value check observes only the undefined pulse. Single-precision requests carry non-zero junk in operand bits [63:32], and both merge settings use a patterned previous destination, so leakage of any ignored bit would appear at the ports.

// File: rtl/fp_trunc_pkg.sv
package fp_trunc_pkg;

   // Format select encodings; codes with bit 1 set are illegal.
   localparam logic [1:0] FMT_SINGLE = 2'b00;
   localparam logic [1:0] FMT_DOUBLE = 2'b01;

   typedef struct packed {
      logic inexact;
      logic invalid;
   } trunc_flags_t;

endpackage

// File: rtl/fp_trunc_core.sv
module fp_trunc_core
   import fp_trunc_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int INT_W = 64
) (
   input  logic [EXP_W+MAN_W:0] op,
   output logic [EXP_W+MAN_W:0] res,
   output trunc_flags_t         flags
);
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
   localparam int LIM_E  = INT_W - 1;
   localparam int SH_W   = $clog2(MAN_W + 1);
   localparam logic [EXP_W-1:0] CLAMP_EXP = EXP_W'(BIAS + LIM_E);

   if (BIAS + LIM_E >= (1 << EXP_W) - 1) begin : g_bad_range
      $error("fp_trunc_core: exponent field too narrow for the integer limit");
   end
   if (MAN_W >= LIM_E) begin : g_bad_man
      $error("fp_trunc_core: fraction width must stay below the integer limit");
   end

   logic             sgn;
   logic [EXP_W-1:0] ex;
   logic [MAN_W-1:0] fr;
   logic [MAN_W-1:0] drop_mask;
   logic [MAN_W-1:0] kept;
   logic [SH_W-1:0]  sh;
   logic             special;
   int               ue;

   assign sgn     = op[EXP_W+MAN_W];
   assign ex      = op[EXP_W+MAN_W-1:MAN_W];
   assign fr      = op[MAN_W-1:0];
   assign special = &ex;

   always_comb begin
      ue            = int'({1'b0, ex}) - BIAS;
      sh            = ue[SH_W-1:0];
      drop_mask     = '0;
      kept          = fr;
      res           = op;
      flags.inexact = 1'b0;
      flags.invalid = 1'b0;
      if (special) begin
         flags.invalid = 1'b1;
      end else if (ex == '0) begin
         // zero or subnormal: magnitude below one
         res           = {sgn, {(EXP_W + MAN_W){1'b0}}};
         flags.inexact = |fr;
      end else if (ue < 0) begin
         res           = {sgn, {(EXP_W + MAN_W){1'b0}}};
         flags.inexact = 1'b1;
      end else if (ue < MAN_W) begin
         drop_mask     = {MAN_W{1'b1}} >> sh;
         kept          = fr & ~drop_mask;
         flags.inexact = |(fr & drop_mask);
         res           = {sgn, ex, kept};
      end
      // range check on the truncated magnitude
      if (!special && ex != '0 && ue >= LIM_E) begin
         if (ue > LIM_E || !(sgn && kept == '0)) begin
            flags.invalid = 1'b1;
         end
      end
      if (flags.invalid) begin
         res           = {1'b1, CLAMP_EXP, {MAN_W{1'b0}}};
         flags.inexact = 1'b0;
      end
   end

endmodule

// File: rtl/fp_trunc_merge.sv
module fp_trunc_merge #(
   parameter int RES_W  = 128,
   parameter int ELEM_W = 32
) (
   input  logic [RES_W-1:0]  prev,
   input  logic              merge,
   input  logic [ELEM_W-1:0] elem,
   output logic [RES_W-1:0]  merged
);
   if (ELEM_W > RES_W) begin : g_bad
      $error("fp_trunc_merge: element wider than destination");
   end else if (ELEM_W == RES_W) begin : g_full
      assign merged = elem;
   end else begin : g_part
      localparam int UP_W = RES_W - ELEM_W;
      logic [UP_W-1:0] upper;
      assign upper  = merge ? prev[RES_W-1:ELEM_W] : {UP_W{1'b0}};
      assign merged = {upper, elem};
   end

endmodule

// File: rtl/fp_trunc_i64.sv
module fp_trunc_i64
   import fp_trunc_pkg::*;
#(
   parameter int RES_W   = 128,
   parameter int INT_W   = 64,
   parameter int SP_EXP  = 8,
   parameter int SP_MAN  = 23,
   parameter int DP_EXP  = 11,
   parameter int DP_MAN  = 52
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       in_fmt,
   input  logic             in_merge,
   input  logic [63:0]      in_operand,
   input  logic [127:0]     in_dest_prev,
   output logic             out_valid,
   output logic [127:0]     out_result,
   output logic             out_inexact,
   output logic             out_invalid,
   output logic             out_undef
);
   localparam int SP_W = 1 + SP_EXP + SP_MAN;
   localparam int DP_W = 1 + DP_EXP + DP_MAN;

   if (RES_W != 128 || DP_W != 64) begin : g_bad_w
      $error("fp_trunc_i64: port widths assume a 128-bit destination and 64-bit double");
   end
   if (SP_W >= DP_W) begin : g_bad_sp
      $error("fp_trunc_i64: single format must be narrower than double");
   end

   logic [SP_W-1:0]  sp_res;
   logic [DP_W-1:0]  dp_res;
   trunc_flags_t     sp_flags;
   trunc_flags_t     dp_flags;
   logic [RES_W-1:0] sp_full;
   logic [RES_W-1:0] dp_full;
   logic [RES_W-1:0] sel_full;
   trunc_flags_t     sel_flags;
   logic             fmt_bad;

   fp_trunc_core #(.EXP_W(SP_EXP), .MAN_W(SP_MAN), .INT_W(INT_W)) u_sp_core (
      .op    (in_operand[SP_W-1:0]),
      .res   (sp_res),
      .flags (sp_flags)
   );

   fp_trunc_core #(.EXP_W(DP_EXP), .MAN_W(DP_MAN), .INT_W(INT_W)) u_dp_core (
      .op    (in_operand[DP_W-1:0]),
      .res   (dp_res),
      .flags (dp_flags)
   );

   fp_trunc_merge #(.RES_W(RES_W), .ELEM_W(SP_W)) u_sp_merge (
      .prev   (in_dest_prev),
      .merge  (in_merge),
      .elem   (sp_res),
      .merged (sp_full)
   );

   fp_trunc_merge #(.RES_W(RES_W), .ELEM_W(DP_W)) u_dp_merge (
      .prev   (in_dest_prev),
      .merge  (in_merge),
      .elem   (dp_res),
      .merged (dp_full)
   );

   assign fmt_bad   = in_fmt[1];
   assign sel_full  = (in_fmt == FMT_DOUBLE) ? dp_full  : sp_full;
   assign sel_flags = (in_fmt == FMT_DOUBLE) ? dp_flags : sp_flags;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_undef   <= 1'b0;
         out_result  <= '0;
         out_inexact <= 1'b0;
         out_invalid <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         out_undef <= 1'b0;
         if (in_valid) begin
            if (fmt_bad) begin
               out_undef <= 1'b1;
            end else begin
               out_valid   <= 1'b1;
               out_result  <= sel_full;
               out_inexact <= sel_flags.inexact;
               out_invalid <= sel_flags.invalid;
            end
         end
      end
   end

endmodule

// File: rtl/fp_trunc_i64_chk.sv
module fp_trunc_i64_chk (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic [1:0]   in_fmt,
   input logic         in_merge,
   input logic [63:0]  in_operand,
   input logic [127:0] in_dest_prev,
   input logic         out_valid,
   input logic [127:0] out_result,
   input logic         out_inexact,
   input logic         out_invalid,
   input logic         out_undef
);

   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_fmt[1]) |=> out_valid);

   a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && !in_fmt[1]) |=> !out_valid);

   a_r9_undef_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_fmt[1]) |=> (out_undef && !out_valid && $stable(out_result)
                                   && $stable(out_inexact) && $stable(out_invalid)));

   a_r5_invalid_excludes_inexact: assert property (@(posedge clk) disable iff (!rst_n)
      out_invalid |-> !out_inexact);

   a_r6_clamp_double: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_fmt == 2'b01) |=>
         (!out_invalid || out_result[63:0] == 64'hC3E0_0000_0000_0000));

   a_r6_clamp_single: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_fmt == 2'b00) |=>
         (!out_invalid || out_result[31:0] == 32'hDF00_0000));

   a_r8_upper_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_fmt == 2'b00 && !in_merge) |=> out_result[127:32] == '0);

   a_r8_upper_merged: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_fmt == 2'b01 && in_merge) |=>
         out_result[127:64] == $past(in_dest_prev[127:64]));

   a_r2_zero_double: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_fmt == 2'b01 && in_operand[62:0] == '0) |=>
         (out_result[63:0] == $past(in_operand) && !out_inexact && !out_invalid));

endmodule

bind fp_trunc_i64 fp_trunc_i64_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_fmt       (in_fmt),
   .in_merge     (in_merge),
   .in_operand   (in_operand),
   .in_dest_prev (in_dest_prev),
   .out_valid    (out_valid),
   .out_result   (out_result),
   .out_inexact  (out_inexact),
   .out_invalid  (out_invalid),
   .out_undef    (out_undef)
);

// File: tb/fp_trunc_i64_tb.sv
module fp_trunc_i64_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   in_fmt = 2'b00;
   logic         in_merge = 1'b0;
   logic [63:0]  in_operand = '0;
   logic [127:0] in_dest_prev = '0;
   logic         out_valid;
   logic [127:0] out_result;
   logic         out_inexact;
   logic         out_invalid;
   logic         out_undef;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit finished = 1'b0;

   logic [127:0] exp_res_q[$];
   logic [1:0]   exp_flag_q[$];
   string        exp_tag_q[$];
   logic [127:0] last_res = '0;
   logic [1:0]   last_flags = '0;

   localparam logic [127:0] PREV_PAT = 128'hA5A5_5A5A_0F0F_F0F0_1234_5678_9ABC_DEF0;
   localparam logic [31:0]  JUNK_HI  = 32'hDEAD_BEEF;

   always #10 clk = ~clk; // 50 MHz

   fp_trunc_i64 u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_fmt       (in_fmt),
      .in_merge     (in_merge),
      .in_operand   (in_operand),
      .in_dest_prev (in_dest_prev),
      .out_valid    (out_valid),
      .out_result   (out_result),
      .out_inexact  (out_inexact),
      .out_invalid  (out_invalid),
      .out_undef    (out_undef)
   );

   // monitor: compare each produced result against the scoreboard head
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         total++;
         if (exp_res_q.size() == 0) begin
            bad++;
            $display("FAIL R10 unexpected out_valid: actual=1 expected=0");
         end else begin
            logic [127:0] er;
            logic [1:0]   ef;
            string        tg;
            er = exp_res_q.pop_front();
            ef = exp_flag_q.pop_front();
            tg = exp_tag_q.pop_front();
            if (out_result !== er || {out_inexact, out_invalid} !== ef) begin
               bad++;
               $display("FAIL %s: actual res=%h inx=%b inv=%b expected res=%h inx=%b inv=%b",
                        tg, out_result, out_inexact, out_invalid, er, ef[1], ef[0]);
            end
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !finished) begin
         finished = 1'b1;
         bad++;
         $display("FAIL watchdog: actual cycles=%0d expected below 20000", cycles);
         $display("test done: total=%0d bad=%0d", total + 1, bad);
         $finish;
      end
   end

   task automatic send(input logic [1:0] fmt, input logic mrg, input logic [63:0] op,
                       input logic [63:0] exp_elem, input logic inx, input logic inv,
                       input string tag);
      logic [127:0] e;
      if (fmt == 2'b00)
         e = {mrg ? PREV_PAT[127:32] : 96'h0, exp_elem[31:0]};
      else
         e = {mrg ? PREV_PAT[127:64] : 64'h0, exp_elem};
      exp_res_q.push_back(e);
      exp_flag_q.push_back({inx, inv});
      exp_tag_q.push_back(tag);
      last_res   = e;
      last_flags = {inx, inv};
      @(negedge clk);
      in_valid     = 1'b1;
      in_fmt       = fmt;
      in_merge     = mrg;
      in_operand   = op;
      in_dest_prev = PREV_PAT;
   endtask

   task automatic sp(input logic [31:0] op, input logic [31:0] r, input logic inx,
                     input logic inv, input string tag);
      send(2'b00, 1'b0, {JUNK_HI, op}, {32'h0, r}, inx, inv, tag);
   endtask

   task automatic dp(input logic [63:0] op, input logic [63:0] r, input logic inx,
                     input logic inv, input string tag);
      send(2'b01, 1'b0, op, r, inx, inv, tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      total++;
      if (out_valid !== 1'b0 || out_undef !== 1'b0 || out_result !== '0 ||
          out_inexact !== 1'b0 || out_invalid !== 1'b0) begin
         bad++;
         $display("FAIL R10 reset: actual v=%b u=%b res=%h f=%b%b expected all zero",
                  out_valid, out_undef, out_result, out_inexact, out_invalid);
      end
      rst_n = 1'b1;

      // single precision
      sp(32'h3FC0_0000, 32'h3F80_0000, 1, 0, "R1 sp +1.5");
      sp(32'hBFC0_0000, 32'hBF80_0000, 1, 0, "R1 sp -1.5");
      sp(32'h4030_0000, 32'h4000_0000, 1, 0, "R1 sp 2.75");
      sp(32'h4A80_0001, 32'h4A80_0000, 1, 0, "R3 sp 2^22+0.5");
      sp(32'h0000_0000, 32'h0000_0000, 0, 0, "R2 sp +0");
      sp(32'h8000_0000, 32'h8000_0000, 0, 0, "R2 sp -0");
      sp(32'h3F00_0000, 32'h0000_0000, 1, 0, "R3 sp +0.5");
      sp(32'hBF00_0000, 32'h8000_0000, 1, 0, "R3 sp -0.5");
      sp(32'h0000_0001, 32'h0000_0000, 1, 0, "R3 sp subnormal");
      sp(32'h8040_0000, 32'h8000_0000, 1, 0, "R3 sp -subnormal");
      sp(32'hC2C8_0000, 32'hC2C8_0000, 0, 0, "R3 sp -100 exact");
      sp(32'h4E80_0000, 32'h4E80_0000, 0, 0, "R4 sp 2^30");
      sp(32'h5EFF_FFFF, 32'h5EFF_FFFF, 0, 0, "R4 sp below 2^63");
      sp(32'hDF00_0000, 32'hDF00_0000, 0, 0, "R6 sp -2^63");
      sp(32'h5F00_0000, 32'hDF00_0000, 0, 1, "R6 sp +2^63");
      sp(32'hDF00_0001, 32'hDF00_0000, 0, 1, "R6 sp beyond -2^63");
      sp(32'h7F7F_FFFF, 32'hDF00_0000, 0, 1, "R6 sp max finite");
      sp(32'h7F80_0000, 32'hDF00_0000, 0, 1, "R5 sp +inf");
      sp(32'hFF80_0000, 32'hDF00_0000, 0, 1, "R5 sp -inf");
      sp(32'h7FC0_0000, 32'hDF00_0000, 0, 1, "R5 sp qnan");
      sp(32'h7F80_0001, 32'hDF00_0000, 0, 1, "R5 sp snan");

      // double precision
      dp(64'h3FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1, 0, "R1 dp +1.5");
      dp(64'hBFF8_0000_0000_0000, 64'hBFF0_0000_0000_0000, 1, 0, "R1 dp -1.5");
      dp(64'h400E_0000_0000_0000, 64'h4008_0000_0000_0000, 1, 0, "R1 dp 3.75");
      dp(64'h4320_0000_0000_0001, 64'h4320_0000_0000_0000, 1, 0, "R3 dp 2^51+0.5");
      dp(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 0, 0, "R2 dp +0");
      dp(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 0, "R2 dp -0");
      dp(64'h3FE0_0000_0000_0000, 64'h0000_0000_0000_0000, 1, 0, "R3 dp +0.5");
      dp(64'hBFE0_0000_0000_0000, 64'h8000_0000_0000_0000, 1, 0, "R3 dp -0.5");
      dp(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, 1, 0, "R3 dp subnormal");
      dp(64'h43DF_FFFF_FFFF_FFFF, 64'h43DF_FFFF_FFFF_FFFF, 0, 0, "R4 dp below 2^63");
      dp(64'hC3E0_0000_0000_0000, 64'hC3E0_0000_0000_0000, 0, 0, "R6 dp -2^63");
      dp(64'h43E0_0000_0000_0000, 64'hC3E0_0000_0000_0000, 0, 1, "R6 dp +2^63");
      dp(64'hC3E0_0000_0000_0001, 64'hC3E0_0000_0000_0000, 0, 1, "R6 dp beyond -2^63");
      dp(64'h7FF0_0000_0000_0000, 64'hC3E0_0000_0000_0000, 0, 1, "R5 dp +inf");
      dp(64'hFFF0_0000_0000_0000, 64'hC3E0_0000_0000_0000, 0, 1, "R5 dp -inf");
      dp(64'h7FF8_0000_0000_0000, 64'hC3E0_0000_0000_0000, 0, 1, "R5 dp qnan");
      dp(64'h7FF0_0000_0000_0001, 64'hC3E0_0000_0000_0000, 0, 1, "R5 dp snan");

      // merge mode, R7 element placement and R8 upper bits
      send(2'b00, 1'b1, {JUNK_HI, 32'h3FC0_0000}, 64'h3F80_0000, 1, 0, "R8 sp merge");
      send(2'b01, 1'b1, 64'h3FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1, 0, "R8 dp merge");
      send(2'b01, 1'b0, 64'h4008_0000_0000_0000, 64'h4008_0000_0000_0000, 0, 0, "R7 dp clear");
      send(2'b00, 1'b1, {JUNK_HI, 32'h7F80_0000}, 64'hDF00_0000, 0, 1, "R7 sp merge inf");
      idle(3);

      // R9: illegal format leaves result and flags unchanged
      for (int k = 2; k < 4; k++) begin
         @(negedge clk);
         in_valid   = 1'b1;
         in_fmt     = 2'(k);
         in_merge   = 1'b0;
         in_operand = 64'h3FF8_0000_0000_0000;
         @(negedge clk);
         in_valid = 1'b0;
         total++;
         if (out_undef !== 1'b1 || out_valid !== 1'b0 || out_result !== last_res ||
             {out_inexact, out_invalid} !== last_flags) begin
            bad++;
            $display("FAIL R9 fmt %0d: actual u=%b v=%b res=%h f=%b%b expected u=1 v=0 res=%h f=%b",
                     k, out_undef, out_valid, out_result, out_inexact, out_invalid,
                     last_res, last_flags);
         end
         @(negedge clk);
         total++;
         if (out_undef !== 1'b0) begin
            bad++;
            $display("FAIL R9 pulse width: actual u=%b expected u=0", out_undef);
         end
      end

      idle(4);
      total++;
      if (exp_res_q.size() != 0) begin
         bad++;
         $display("FAIL R10 missing results: actual pending=%0d expected 0", exp_res_q.size());
      end
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule